// File: doc/BRIEF.md
# Sync-Polarity Vertical Line Counter

This block gives an on-screen display overlay its vertical position. It watches the raw horizontal and vertical sync inputs of a video source and counts lines: every accepted vertical sync edge restarts the count, and every later accepted horizontal sync edge advances it by one. The count is compared against a programmed start line. In the clock cycle after the increment that reaches that line, a one-clock match pulse is raised, and the overlay uses this pulse to begin drawing.

Each sync input has its own polarity select, so either signal can be active-high or active-low. Both inputs are first resynchronised to the block clock. A width filter then rejects pulses that are shorter than a minimum number of machine cycles. The machine cycles are marked by a clock-enable input, and the filter, the guard window and the counter advance only on enabled cycles. Right after each vertical sync edge there is a short guard window. A horizontal sync edge that lands inside this window is not counted, so an edge that arrives almost together with the vertical edge cannot make the first line jitter. A new polarity setting is applied only at a vertical sync edge, so no frame is ever counted with a mix of old and new settings.

Top module: `vlc_vline_counter`

## Requirements
- R1: While rst_n is low and after it rises, line_count is 0 and line_match is 0. Both stored polarities are positive (rising edge active) until the first vertical edge loads the selects.
- R2: Each raw sync input passes through two clock flops before filtering. With cyc_en high, a qualifying raw change driven before clock edge 1 changes line_count at clock edge 10 and not before.
- R3: A filtered sync level changes only after the synchronised raw level has differed from it on MIN_W (8) consecutive enabled cycles. A pulse of 7 machine cycles is ignored and a pulse of 8 is accepted.
- R4: Select value 0 makes the rising edge of a sync input active and value 1 makes its falling edge active. hsync_neg applies to the horizontal input and vsync_neg to the vertical input, each on its own.
- R5: A change on either select takes effect only at the next active vertical edge, which is detected with the polarity stored before that change. At that edge both stored polarities load from the selects.
- R6: An active vertical edge clears line_count to 0.
- R7: A horizontal active edge on any of the GUARD (3) enabled cycles that follow an active vertical edge is not counted. Edges from the 4th enabled cycle onward are counted.
- R8: Each counted horizontal active edge raises line_count by exactly 1.
- R9: line_count saturates at 1023 and never wraps.
- R10: line_match is high for exactly one clock after an increment that makes line_count equal start_line. It never fires when start_line is 0, and it never fires on an edge that finds the count already saturated.
- R11: While cyc_en is low, the filters, the guard window and line_count all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle enable |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| hsync_neg | input | 1 | Horizontal polarity select, 1 = falling edge active |
| vsync_neg | input | 1 | Vertical polarity select, 1 = falling edge active |
| start_line | input | 10 | Programmed vertical start line |
| line_count | output | 10 | Current line count |
| line_match | output | 1 | One-clock pulse when the count reaches start_line |

## Verification
The hardest situation to reach is the exact edge of the guard window. A horizontal edge has to arrive a precise number of enabled cycles after the vertical edge, and both edges pass through the same synchroniser and filter delay. The stimulus therefore starts both raw pulses inside one loop, with a chosen offset between them. Offsets of 3 and 4 cycles place the filtered horizontal edge just inside and just outside the window. The select-deferral case is reached in a similar way: the selects are flipped in the middle of a frame while the raw pulses keep their old polarity, and the next vertical pulse is the point where the new setting has to appear.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    typedef enum logic [0:0] {
        CH_H = 1'b0,
        CH_V = 1'b1
    } vlc_chan_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/vlc_sync2.sv
module vlc_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stab;
endmodule

// File: rtl/vlc_width_filter.sv
module vlc_width_filter #(
    parameter int unsigned MIN_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    localparam int unsigned RUN_W = $clog2(MIN_W + 1);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     flip;

    always_comb begin
        st_d = st_q;
        flip = 1'b0;
        if (cyc_en) begin
            if (sig_in != st_q.lvl) begin
                if (st_q.run == RUN_W'(MIN_W - 1)) begin
                    flip       = 1'b1;
                    st_d.lvl   = sig_in;
                    st_d.run   = '0;
                end else begin
                    st_d.run = st_q.run + RUN_W'(1);
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = flip &  sig_in;
    assign fall = flip & ~sig_in;
endmodule

// File: rtl/vlc_line_ctr.sv
module vlc_line_ctr #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned GUARD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             v_edge,
    input  logic             h_edge,
    input  logic [CNT_W-1:0] start_line,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    localparam int unsigned GW = $clog2(GUARD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [GW-1:0]    guard;
        logic             match;
    } ctr_st_t;

    ctr_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = st_q.cnt + CNT_W'(1);

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        if (cyc_en) begin
            if (v_edge) begin
                st_d.cnt   = '0;
                st_d.guard = GW'(GUARD);
            end else begin
                if (h_edge && st_q.guard == '0 && st_q.cnt != '1) begin
                    st_d.cnt   = cnt_inc;
                    st_d.match = (cnt_inc == start_line);
                end
                if (st_q.guard != '0) st_d.guard = st_q.guard - GW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign match = st_q.match;
endmodule

// File: rtl/vlc_vline_counter.sv
module vlc_vline_counter
    import vlc_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned MIN_W = 8,
    parameter int unsigned GUARD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             hsync_neg,
    input  logic             vsync_neg,
    input  logic [CNT_W-1:0] start_line,
    output logic [CNT_W-1:0] line_count,
    output logic             line_match
);
    typedef struct packed {
        logic h_neg;
        logic v_neg;
    } pol_st_t;

    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] synced;
    logic [NUM_CH-1:0] f_rise;
    logic [NUM_CH-1:0] f_fall;
    pol_st_t           pol_d, pol_q;
    logic              v_act, h_act;

    assign raw_in[CH_H] = hsync_in;
    assign raw_in[CH_V] = vsync_in;

    vlc_sync2 #(.WIDTH(NUM_CH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (synced)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
        vlc_width_filter #(.MIN_W(MIN_W)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .cyc_en(cyc_en),
            .sig_in(synced[ch]),
            .rise  (f_rise[ch]),
            .fall  (f_fall[ch])
        );
    end

    assign v_act = pol_q.v_neg ? f_fall[CH_V] : f_rise[CH_V];
    assign h_act = pol_q.h_neg ? f_fall[CH_H] : f_rise[CH_H];

    always_comb begin
        pol_d = pol_q;
        if (v_act) begin
            pol_d.h_neg = hsync_neg;
            pol_d.v_neg = vsync_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

    vlc_line_ctr #(.CNT_W(CNT_W), .GUARD(GUARD)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .v_edge    (v_act),
        .h_edge    (h_act),
        .start_line(start_line),
        .count     (line_count),
        .match     (line_match)
    );
endmodule

// File: rtl/vlc_vline_counter_chk.sv
module vlc_vline_counter_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic [CNT_W-1:0] start_line,
    input logic [CNT_W-1:0] line_count,
    input logic             line_match
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_match |=> !line_match); // R10

    AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        line_match |-> (line_count == $past(start_line))); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_count != $past(line_count)) |->
            (line_count == '0 || line_count == $past(line_count) + CNT_W'(1))); // R8

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(line_count)); // R11

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_count == MAXV) |=> (line_count == MAXV || line_count == '0)); // R9
endmodule

bind vlc_vline_counter vlc_vline_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/vlc_vline_counter_tb.sv
module vlc_vline_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1;
    logic       hs_raw = 1'b0, vs_raw = 1'b0;
    logic       hsel = 1'b0, vsel = 1'b0;
    logic [9:0] start_line = 10'd0;
    logic [9:0] line_count;
    logic       line_match;

    int checks = 0, errors = 0, cycles = 0, match_cnt = 0;
    int en_mode = 0;
    bit hidle = 0, vidle = 0;

    always #2 clk = ~clk;

    vlc_vline_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
        .hsync_in(hs_raw), .vsync_in(vs_raw),
        .hsync_neg(hsel), .vsync_neg(vsel),
        .start_line(start_line),
        .line_count(line_count), .line_match(line_match)
    );

    // behavioural reference model
    int m_s1[2], m_s2[2], m_lvl[2], m_run[2];
    int m_cnt, m_guard, m_hp, m_vp;
    bit m_match;

    always @(posedge clk) begin
        int raw[2];
        int rose[2], fell[2];
        int ve, he;
        raw[0] = hs_raw; raw[1] = vs_raw;
        if (!rst_n) begin
            foreach (m_s1[i]) begin
                m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_run[i] = 0;
            end
            m_cnt = 0; m_guard = 0; m_hp = 0; m_vp = 0; m_match = 0;
        end else begin
            m_match = 0;
            for (int i = 0; i < 2; i++) begin
                rose[i] = 0; fell[i] = 0;
                if (cyc_en) begin
                    if (m_s2[i] != m_lvl[i]) begin
                        if (m_run[i] == 7) begin
                            m_lvl[i] = m_s2[i]; m_run[i] = 0;
                            if (m_lvl[i] == 1) rose[i] = 1; else fell[i] = 1;
                        end else m_run[i]++;
                    end else m_run[i] = 0;
                end
            end
            for (int i = 0; i < 2; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = raw[i];
            end
            ve = m_vp ? fell[1] : rose[1];
            he = m_hp ? fell[0] : rose[0];
            if (cyc_en) begin
                if (ve) begin
                    m_cnt = 0; m_guard = 3; m_hp = hsel; m_vp = vsel;
                end else begin
                    if (he && m_guard == 0 && m_cnt < 1023) begin
                        m_cnt++;
                        if (m_cnt == start_line) m_match = 1;
                    end
                    if (m_guard > 0) m_guard--;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (line_count != 10'(m_cnt)) begin
                errors++;
                $display("FAIL R8 line_count model act=%0d exp=%0d", line_count, m_cnt);
            end
            checks++;
            if (line_match != m_match) begin
                errors++;
                $display("FAIL R10 line_match model act=%0d exp=%0d", line_match, m_match);
            end
            if (line_match) match_cnt++;
        end
    end

    always @(negedge clk) begin
        if (en_mode == 1) cyc_en <= ~cyc_en;
        else if (en_mode == 2) cyc_en <= 1'b0;
        else cyc_en <= 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(int vlen, int hoff, int hlen, int total);
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            vs_raw = vidle ^ (i < vlen);
            hs_raw = hidle ^ (i >= hoff && i < hoff + hlen);
        end
    endtask

    task automatic hpulse(int w, int gap);
        run_seq(0, 0, w, w + gap);
    endtask

    task automatic vframe(int hoff);
        run_seq(12, hoff, 10, 40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 count in reset", line_count, 0);
        check_eq("R1 match in reset", line_match, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 count after reset", line_count, 0);

        vframe(100);
        check_eq("R6 cleared by frame", line_count, 0);
        for (int k = 0; k < 5; k++) hpulse(10, 10);
        check_eq("R8 five lines", line_count, 5);

        // R2 latency: change at edge 10
        @(negedge clk); hs_raw = 1'b1;
        repeat (9) @(negedge clk);
        check_eq("R2 not yet counted", line_count, 5);
        @(negedge clk);
        check_eq("R2 counted at edge 10", line_count, 6);
        repeat (2) @(negedge clk); hs_raw = 1'b0;
        repeat (12) @(negedge clk);

        hpulse(7, 12);
        check_eq("R3 seven-cycle pulse ignored", line_count, 6);
        hpulse(8, 12);
        check_eq("R3 eight-cycle pulse accepted", line_count, 7);

        vframe(3);
        check_eq("R7 edge inside guard ignored", line_count, 0);
        vframe(4);
        check_eq("R7 edge after guard counted", line_count, 1);

        start_line = 10'd3; match_cnt = 0;
        vframe(100);
        for (int k = 0; k < 5; k++) hpulse(10, 10);
        check_eq("R10 one match at line 3", match_cnt, 1);
        start_line = 10'd0; match_cnt = 0;
        vframe(100);
        for (int k = 0; k < 3; k++) hpulse(10, 10);
        check_eq("R10 no match for line 0", match_cnt, 0);

        // R5 deferral: selects flip mid-frame, old rising edge still active
        hsel = 1'b1; vsel = 1'b1;
        check_eq("R5 count before", line_count, 3);
        @(negedge clk); hs_raw = 1'b1;
        repeat (10) @(negedge clk);
        check_eq("R5 old rising polarity kept", line_count, 4);
        repeat (2) @(negedge clk); hs_raw = 1'b0;
        repeat (12) @(negedge clk);
        vframe(100);
        check_eq("R5 loaded at vertical edge", line_count, 0);
        hidle = 1; vidle = 1;
        run_seq(0, 100, 0, 20);
        check_eq("R4 rising edge inactive when negative", line_count, 0);
        @(negedge clk); hs_raw = 1'b0;
        repeat (10) @(negedge clk);
        check_eq("R4 falling edge counts", line_count, 1);
        repeat (2) @(negedge clk); hs_raw = 1'b1;
        repeat (12) @(negedge clk);
        check_eq("R4 trailing rise ignored", line_count, 1);
        hpulse(10, 10);
        check_eq("R4 negative pulse counted", line_count, 2);
        vframe(100);
        check_eq("R4 negative vertical clears", line_count, 0);
        hsel = 1'b0; vsel = 1'b0;
        vframe(100);
        hidle = 0; vidle = 0;
        run_seq(0, 100, 0, 20);
        hpulse(10, 10);
        check_eq("R4 back to positive", line_count, 1);

        start_line = 10'd1023; match_cnt = 0;
        vframe(100);
        for (int k = 0; k < 1030; k++) hpulse(8, 8);
        check_eq("R9 saturated", line_count, 1023);
        check_eq("R10 single match at saturation line", match_cnt, 1);

        en_mode = 1;
        run_seq(24, 200, 0, 60);
        check_eq("R11 frame with sparse enable", line_count, 0);
        for (int k = 0; k < 3; k++) hpulse(20, 20);
        check_eq("R11 sparse enable lines", line_count, 3);
        en_mode = 2;
        for (int k = 0; k < 2; k++) hpulse(20, 20);
        check_eq("R11 held without enable", line_count, 3);
        en_mode = 0;
        repeat (20) @(negedge clk);
        check_eq("R11 still held after enable returns", line_count, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule